// File: doc/BRIEF.md
# Output DC-Offset Detector

This block watches the two half-bridge drive levels of a filterless class-D output stage and decides whether the load is being driven with a sustained DC component. Over every carrier period it counts how many clock cycles the positive-side drive was high and how many the negative-side drive was high. The difference between the two counts, taken as a share of the period, is the differential duty cycle. A period is "in excess" when the size of that difference is strictly larger than a threshold percentage of the period.

A persistence counter counts in-excess periods of one sign. A period that is not in excess, or that is in excess with the opposite sign, ends the current run. When the run reaches the trip length, a fault flag is set and stays set until the block is reset. Symmetric audio moves the imbalance back and forth faster than the window, so only DC or near-DC drive can build a full run. While the modulator enable is low, the period phase and the run counter stay at zero.

Top module: `dc_offset_detect`

## Requirements
- R1: After reset, `dc_fault` is 0.
- R2: A carrier period of PERIOD_CYC cycles is in excess only when |P - N| * 100 > THRESH_PCT * PERIOD_CYC, where P and N are the counts of cycles in that period with `drv_pos` high and with `drv_neg` high. Equal drive, or an imbalance exactly at the threshold, never counts.
- R3: When TRIP_PERIODS consecutive enabled periods are in excess with the same sign, `dc_fault` rises within three clock edges after the last cycle of the final period. This holds for both signs. One period fewer never sets the fault.
- R4: An in-excess period whose sign (P > N positive, P < N negative) differs from the current run restarts the run at one.
- R5: An enabled period that is not in excess clears the run.
- R6: While `mod_en` is low, the run count and the period phase are held at zero. A period whose measurement completes while `mod_en` is low does not count. When `mod_en` rises, a new period starts on the first enabled cycle.
- R7: Once set, `dc_fault` stays at 1 whatever the drive and `mod_en` do. Only `rst_n` clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the only way to clear the fault |
| mod_en | input | 1 | Modulator enable; detection is suspended while low |
| drv_pos | input | 1 | Positive-side drive level |
| drv_neg | input | 1 | Negative-side drive level |
| dc_fault | output | 1 | Sticky DC-offset fault flag |

## Verification
Two events can land on the same cycle. The first is the measurement of the period that would complete a run. The second is the fall of the enable, which must discard that same measurement. The bench builds a run one period short of the trip length. It drives the tripping period and lowers `mod_en` on the cycle right after that period's last cycle, so the measurement arrives while the block is disabled. The fault must stay low. A second run must then need the full trip length again before the fault rises. A sign reversal on what would have been the tripping period is judged the same way: the run restarts at one and no fault appears.

// File: rtl/dcdet_pkg.sv
package dcdet_pkg;

  typedef enum logic {
    POL_POS = 1'b0,
    POL_NEG = 1'b1
  } pol_e;

  // Imbalance test: |diff| as a percentage of the period, strictly above the limit
  function automatic logic exceeds_limit(input int diff, input int period, input int pct);
    int mag;
    mag = (diff < 0) ? -diff : diff;
    return (mag * 100) > (pct * period);
  endfunction

  // Saturating increment of the persistence count
  function automatic int next_count(input int cur, input int lim);
    return (cur >= lim) ? lim : cur + 1;
  endfunction

endpackage

// File: rtl/duty_meter.sv
module duty_meter #(
  parameter int PERIOD_CYC = 400
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 en,
  input  logic                                 drv_pos,
  input  logic                                 drv_neg,
  output logic                                 meas_valid,
  output logic signed [$clog2(PERIOD_CYC+1):0] meas_diff
);
  localparam int CW = $clog2(PERIOD_CYC + 1);
  localparam logic [CW-1:0] LAST_PH = CW'(PERIOD_CYC - 1);

  logic [CW-1:0] phase_q, cnt_p_q, cnt_n_q;
  logic [CW-1:0] p_now, n_now;
  logic          period_end;

  assign period_end = (phase_q == LAST_PH);
  assign p_now      = cnt_p_q + CW'(drv_pos);
  assign n_now      = cnt_n_q + CW'(drv_neg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= '0;
      cnt_p_q    <= '0;
      cnt_n_q    <= '0;
      meas_valid <= 1'b0;
      meas_diff  <= '0;
    end else if (!en) begin
      phase_q    <= '0;
      cnt_p_q    <= '0;
      cnt_n_q    <= '0;
      meas_valid <= 1'b0;
    end else begin
      meas_valid <= period_end;
      if (period_end) begin
        phase_q   <= '0;
        cnt_p_q   <= '0;
        cnt_n_q   <= '0;
        meas_diff <= $signed({1'b0, p_now}) - $signed({1'b0, n_now});
      end else begin
        phase_q <= phase_q + 1'b1;
        cnt_p_q <= p_now;
        cnt_n_q <= n_now;
      end
    end
  end

  AST_PHASE_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (phase_q == '0)); // R6
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_p_q <= phase_q) && (cnt_n_q <= phase_q)); // R2
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid |=> !meas_valid); // R2

endmodule

// File: rtl/persist_timer.sv
module persist_timer
  import dcdet_pkg::*;
#(
  parameter int PERIOD_CYC   = 400,
  parameter int THRESH_PCT   = 14,
  parameter int TRIP_PERIODS = 105000
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 en,
  input  logic                                 meas_valid,
  input  logic signed [$clog2(PERIOD_CYC+1):0] meas_diff,
  output logic                                 trip
);
  localparam int CW = $clog2(PERIOD_CYC + 1);
  localparam int TW = $clog2(TRIP_PERIODS + 1);
  localparam logic [TW-1:0] TRIP_V = TW'(TRIP_PERIODS);

  logic [TW-1:0] count_q;
  pol_e          pol_q, pol_now;
  logic          excess, restart;

  always_comb begin
    excess  = exceeds_limit(int'(meas_diff), PERIOD_CYC, THRESH_PCT);
    pol_now = meas_diff[CW] ? POL_NEG : POL_POS;
    restart = (count_q == '0) || (pol_now != pol_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      pol_q   <= POL_POS;
    end else if (!en) begin
      count_q <= '0;
    end else if (meas_valid) begin
      if (!excess) begin
        count_q <= '0;
      end else if (restart) begin
        count_q <= TW'(1);
        pol_q   <= pol_now;
      end else begin
        count_q <= TW'(next_count(int'(count_q), TRIP_PERIODS));
      end
    end
  end

  assign trip = (count_q == TRIP_V);

  AST_TIMER_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= TRIP_V); // R3
  AST_DISABLE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (count_q == '0)); // R6
  AST_SIGN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (en && meas_valid && excess && (pol_now != pol_q)) |=> (count_q == TW'(1))); // R4
  AST_CALM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (en && meas_valid && !excess) |=> (count_q == '0)); // R5

endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= flag_o | set_i;
  end

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o |=> flag_o); // R7
  AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(set_i)); // R3

endmodule

// File: rtl/dc_offset_detect.sv
module dc_offset_detect #(
  parameter int PERIOD_CYC   = 400,
  parameter int THRESH_PCT   = 14,
  parameter int TRIP_PERIODS = 105000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mod_en,
  input  logic drv_pos,
  input  logic drv_neg,
  output logic dc_fault
);
  localparam int CW = $clog2(PERIOD_CYC + 1);

  logic                 meas_valid;
  logic signed [CW:0]   meas_diff;
  logic                 trip;

  duty_meter #(.PERIOD_CYC(PERIOD_CYC)) meter_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (mod_en),
    .drv_pos    (drv_pos),
    .drv_neg    (drv_neg),
    .meas_valid (meas_valid),
    .meas_diff  (meas_diff)
  );

  persist_timer #(
    .PERIOD_CYC   (PERIOD_CYC),
    .THRESH_PCT   (THRESH_PCT),
    .TRIP_PERIODS (TRIP_PERIODS)
  ) timer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (mod_en),
    .meas_valid (meas_valid),
    .meas_diff  (meas_diff),
    .trip       (trip)
  );

  sticky_flag latch_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (trip),
    .flag_o (dc_fault)
  );

  AST_RESET_CLEAN: assert property (@(posedge clk)
    !rst_n |-> !dc_fault); // R1

endmodule

// File: tb/dc_offset_detect_tb.sv
module dc_offset_detect_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int P    = 50;
  localparam int PCT  = 14;
  localparam int TRIP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mod_en = 1'b0;
  logic drv_pos = 1'b0;
  logic drv_neg = 1'b0;
  logic dc_fault;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  int m_cnt = 0;
  bit m_neg = 1'b0;
  bit m_fault = 1'b0;

  bit    exp_q[$];
  string tag_q[$];
  event  pushed_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  dc_offset_detect #(.PERIOD_CYC(P), .THRESH_PCT(PCT), .TRIP_PERIODS(TRIP)) dut_i (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en),
    .drv_pos(drv_pos), .drv_neg(drv_neg), .dc_fault(dc_fault)
  );

  task automatic check(input bit ok, input string tag, input bit act, input bit exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: dc_fault=%0b expected %0b", tag, act, exp);
    end
  endtask

  // Driver: one carrier period, model update, expected item pushed
  task automatic run_period(input int ph, input int nh, input bit en, input bit drop,
                            input string tag);
    int  d;
    bit  big, neg;
    mod_en = en;
    for (int i = 0; i < P; i++) begin
      drv_pos = (i < ph);
      drv_neg = (i < nh);
      @(negedge clk);
    end
    drv_pos = 1'b0;
    drv_neg = 1'b0;
    d   = ph - nh;
    big = (((d < 0) ? -d : d) * 100) > (PCT * P);
    neg = (d < 0);
    if (!en || drop)                      m_cnt = 0;
    else if (!big)                        m_cnt = 0;
    else if (m_cnt == 0 || neg != m_neg) begin m_cnt = 1; m_neg = neg; end
    else if (m_cnt < TRIP)                m_cnt++;
    if (m_cnt == TRIP) m_fault = 1'b1;
    exp_q.push_back(m_fault);
    tag_q.push_back(tag);
    -> pushed_ev;
    if (drop) begin
      mod_en = 1'b0;
      @(negedge clk);
    end
  endtask

  // Monitor: sample three negedges after each period end
  initial begin
    bit    e;
    string t;
    forever begin
      @(pushed_ev);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      repeat (3) @(negedge clk);
      check(dc_fault === e, t, dc_fault, e);
    end
  end

  initial begin
    repeat (200000) @(negedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(dc_fault === 1'b0, "R1 reset state", dc_fault, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check(dc_fault === 1'b0, "R1 after release", dc_fault, 1'b0);

    for (int k = 0; k < 3; k++) run_period(25, 25, 1'b1, 1'b0, "R2 balanced");
    for (int k = 0; k < 8; k++) run_period(32, 25, 1'b1, 1'b0, "R2 at threshold");
    for (int k = 0; k < 5; k++) run_period(33, 25, 1'b1, 1'b0, "R3 one short");
    run_period(25, 25, 1'b1, 1'b0, "R5 calm period clears");
    for (int k = 0; k < 5; k++) run_period(40, 10, 1'b1, 1'b0, "R5 rebuilt run");
    run_period(10, 40, 1'b1, 1'b0, "R4 sign flip at trip slot");
    for (int k = 0; k < 4; k++) run_period(10, 40, 1'b1, 1'b0, "R4 restarted run");
    run_period(10, 40, 1'b0, 1'b0, "R6 disabled period");
    for (int k = 0; k < 5; k++) run_period(10, 40, 1'b1, 1'b0, "R6 run after enable");
    run_period(10, 40, 1'b1, 1'b1, "R6 enable drop meets trip");
    for (int k = 0; k < 5; k++) run_period(10, 40, 1'b1, 1'b0, "R6 fresh run");
    run_period(10, 40, 1'b1, 1'b0, "R3 negative trip");
    for (int k = 0; k < 3; k++) run_period(10, 40, 1'b1, 1'b0, "R7 held under drive");
    for (int k = 0; k < 2; k++) run_period(25, 25, 1'b1, 1'b0, "R7 held when calm");
    run_period(25, 25, 1'b0, 1'b0, "R7 held when disabled");

    repeat (6) @(negedge clk);
    check(dc_fault === 1'b1, "R7 before reset", dc_fault, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    check(dc_fault === 1'b0, "R7 cleared by reset", dc_fault, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule